// File: doc/BRIEF.md
# Multi-Level Page Table Walker

A sequential address translator that turns a 64-bit virtual page address into a real page address. It reads translation tables one 64-bit entry at a time through a simple memory read port. There are up to five table levels: three region levels, then segment, then page. The walk starts at the level named by the type field of the selected address-space descriptor. Before it walks, the block checks the address against the range that this descriptor type allows.

It also handles four cases that skip part or all of the walk:
- translation switched off;
- a descriptor that maps real space directly;
- optional 1 MB leaf pages taken at the segment level;
- a secondary-space mode, in which instruction fetches use the primary descriptor and data accesses use the secondary one.

Each request ends in exactly one response. The response is either a real address with read/write/execute permissions, or a fault with a code and a translation-exception word. The requester offers a request while `reqReady` is high. `reqReady` stays low until the response pulse.

Top module: `page_walker`

## Requirements
- R1: After reset `reqReady` is 1, and `rspValid` and `memReqValid` are 0. `rspValid` is a single-cycle pulse per accepted request.
- R2: With `xlateEn`=0 the result is the virtual address with bits 11:0 cleared, and perm is 3'b111 (bit2 execute, bit1 write, bit0 read). No memory read is made.
- R3: With `addr64`=0, virtual-address bits 63:31 are cleared before any other step, including when translation is off.
- R4: `reqSpace` selects the descriptor: 2'b00 primary, 2'b10 secondary, 2'b11 home. The value 2'b01 gives a translation-specification fault (code 8'h12) whose exception word is the page-aligned virtual address with space code 0. The space codes placed in exception words are primary 1, secondary 2 and home 3.
- R5: The descriptor type is bits 3:2 (3 first region, 2 second region, 1 third region, 0 segment). For type 2, 1 or 0, any set virtual-address bit at or above bit 53, 42 or 31 respectively gives fault 8'h12 with word = address | space code.
- R6: A descriptor with bit 5 set bypasses the walk. The result is the virtual address with perm 3'b111 (subject to R12), and no memory read is made.
- R7: The walk reads the first table at the descriptor's level. The descriptor and region-entry origins are bits 63:12; the segment-entry origin is bits 63:11. Each entry address is origin + 8 × index. The index is taken from virtual-address bits 63:53, 52:42, 41:31 and 30:20 for the first-region, second-region, third-region and segment tables, and bits 19:12 for the page table.
- R8: For a region or segment entry, bit 5 set gives a segment-translation fault (8'h10). Otherwise, a type field (bits 3:2) that differs from the type of the table it points to gives fault 8'h12. A segment entry must hold type 0. On any fault, rspRaddr and rspPerm are 0.
- R9: In a page entry, bit 10 set gives a page-translation fault (8'h11). Otherwise the real address is entry bits 63:12. Fault words for R8 and R9 are address | space code.
- R10: With `largePageEn`=1, a segment entry with bit 10 set is a leaf. Its real address is entry bits 63:20 joined to virtual-address bits 19:12. With `largePageEn`=0 that bit has no effect and the walk continues to the page table.
- R11: Bit 9 of a page entry or of a large-page segment entry clears write permission. A write (`reqAccess`=2'b01; 2'b00 is read, 2'b10 is fetch) to such a page gives a protection fault (8'h04) with word = address | space code | 4.
- R12: In secondary mode with translation on, a fetch uses the primary descriptor (space code 1) and returns only execute permission. A data access uses the secondary descriptor and loses execute permission.
- R13: At most one memory read is outstanding. `reqReady` stays low from the accepting edge until the edge that raises `rspValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Walker idle, request accepted when both high |
| reqVaddr | input | 64 | Virtual address |
| reqAccess | input | 2 | 00 read, 01 write, 10 fetch |
| reqSpace | input | 2 | Address-space selector |
| xlateEn | input | 1 | Translation enabled |
| addr64 | input | 1 | 64-bit addressing (0 = 31-bit) |
| largePageEn | input | 1 | Allow 1 MB segment leaves |
| descPrimary | input | 64 | Primary space descriptor |
| descSecondary | input | 64 | Secondary space descriptor |
| descHome | input | 64 | Home space descriptor |
| memReqValid | output | 1 | Table read request pulse |
| memAddr | output | 64 | Table entry address |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 64 | Table entry |
| rspValid | output | 1 | Result pulse |
| rspRaddr | output | 64 | Real page address |
| rspPerm | output | 3 | {execute, write, read} |
| rspFault | output | 1 | Result is a fault |
| rspCode | output | 8 | Fault code |
| rspExcWord | output | 64 | Translation-exception word |

## Verification
A wrong level register shows up first as a wrong `memAddr` on the next read. It then shows as a wrong real address, or a type-mismatch fault, in the response that follows, which comes one memory turnaround later. A stale space code or a stale access type changes the exception word or the permissions of the very response it belongs to. A control state stuck busy holds `reqReady` low, which stalls the next request at once. The table vectors cover every exit of the walk at each level, so each fault kind and each leaf kind is compared field by field.

// File: rtl/walk_pkg.sv
package walk_pkg;
  localparam int VA_W     = 64;
  localparam int IDX_W    = 11;              // region/segment index width
  localparam int PIDX_W   = 8;               // page index width
  localparam int PAGE_SH  = 12;
  localparam int LARGE_SH = PAGE_SH + PIDX_W;
  localparam int NARROW_W = 31;
  localparam int LVL_W    = 3;
  localparam int CODE_W   = 8;
  localparam int PERM_W   = 3;
  localparam logic [LVL_W-1:0] TOP_LVL = 3'd4;

  localparam logic [1:0] ACC_READ  = 2'b00;
  localparam logic [1:0] ACC_WRITE = 2'b01;
  localparam logic [1:0] ACC_FETCH = 2'b10;

  localparam logic [1:0] SP_PRI  = 2'b00;
  localparam logic [1:0] SP_AR   = 2'b01;
  localparam logic [1:0] SP_SEC  = 2'b10;
  localparam logic [1:0] SP_HOME = 2'b11;

  localparam logic [CODE_W-1:0] FC_PROT  = 8'h04;
  localparam logic [CODE_W-1:0] FC_SEGX  = 8'h10;
  localparam logic [CODE_W-1:0] FC_PAGEX = 8'h11;
  localparam logic [CODE_W-1:0] FC_SPEC  = 8'h12;

  typedef struct packed {
    logic capture;   // request accepted this cycle
    logic step;      // table entry arrived this cycle
  } walkStrobe_t;

  typedef struct packed {
    logic              fault;
    logic [CODE_W-1:0] code;
    logic [VA_W-1:0]   raddr;
    logic [PERM_W-1:0] perm;
    logic [VA_W-1:0]   word;
  } rsp_t;

  function automatic logic [VA_W-1:0] tableOffset(logic [LVL_W-1:0] lvl, logic [VA_W-1:0] va);
    logic [VA_W-1:0] off;
    logic [VA_W-1:0] sh;
    off = '0;
    if (lvl == '0) begin
      off[PIDX_W+2:3] = va[PAGE_SH +: PIDX_W];
    end else begin
      sh = va >> (LARGE_SH + IDX_W * (int'(lvl) - 1));
      off[IDX_W+2:3] = sh[IDX_W-1:0];
    end
    return off;
  endfunction

  function automatic rsp_t faultRsp(logic [CODE_W-1:0] code, logic [VA_W-1:0] word);
    rsp_t r;
    r = '0;
    r.fault = 1'b1;
    r.code  = code;
    r.word  = word;
    return r;
  endfunction

  function automatic rsp_t leafRsp(logic [VA_W-1:0] ra, logic ro, logic [1:0] acc,
                                   logic secMask, logic [VA_W-1:0] va, logic [1:0] sc);
    rsp_t r;
    if (acc == ACC_WRITE && ro) return faultRsp(FC_PROT, va | VA_W'(sc) | VA_W'(4));
    r = '0;
    r.raddr = ra;
    r.perm  = {1'b1, !ro, 1'b1};
    if (secMask) r.perm = r.perm & ((acc == ACC_FETCH) ? 3'b100 : 3'b011);
    return r;
  endfunction
endpackage

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        needWalk,
  input  logic        memRspValid,
  input  logic        walkDone,
  output logic        reqReady,
  output walkStrobe_t strobe
);
  typedef enum logic {ST_IDLE, ST_BUSY} state_e;
  state_e state;

  always_comb begin
    strobe.capture = (state == ST_IDLE) && reqValid;
    strobe.step    = (state == ST_BUSY) && memRspValid;
  end

  assign reqReady = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else if (strobe.capture && needWalk) begin
      state <= ST_BUSY;
    end else if (strobe.step && walkDone) begin
      state <= ST_IDLE;
    end
  end

  // R13: an entry arriving while idle is never consumed as a step
  assert_no_idle_step_R13: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && memRspValid) |-> !strobe.step);
endmodule

// File: rtl/walk_datapath.sv
module walk_datapath
  import walk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strobe,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic [1:0]        reqAccess,
  input  logic [1:0]        reqSpace,
  input  logic              xlateEn,
  input  logic              addr64,
  input  logic              largePageEn,
  input  logic [VA_W-1:0]   descPrimary,
  input  logic [VA_W-1:0]   descSecondary,
  input  logic [VA_W-1:0]   descHome,
  input  logic [VA_W-1:0]   memRspData,
  output logic              needWalk,
  output logic              walkDone,
  output logic              memReqValid,
  output logic [VA_W-1:0]   memAddr,
  output logic              rspValid,
  output rsp_t              rspOut
);
  // ---- request decode ----
  logic [VA_W-1:0]  vaIn, descIn, startAddr;
  logic [1:0]       useSpace, scIn, descType;
  logic [LVL_W-1:0] startLevel;
  logic             badSpace, rangeBad, secMaskIn;

  always_comb begin
    vaIn = reqVaddr;
    if (!addr64) vaIn[VA_W-1:NARROW_W] = '0;
    vaIn[PAGE_SH-1:0] = '0;
    secMaskIn = xlateEn && (reqSpace == SP_SEC);
    useSpace  = (reqSpace == SP_SEC && reqAccess == ACC_FETCH) ? SP_PRI : reqSpace;
    badSpace  = (reqSpace == SP_AR);
    case (useSpace)
      SP_PRI:  begin scIn = 2'd1; descIn = descPrimary;   end
      SP_SEC:  begin scIn = 2'd2; descIn = descSecondary; end
      SP_HOME: begin scIn = 2'd3; descIn = descHome;      end
      default: begin scIn = 2'd0; descIn = descPrimary;   end
    endcase
    descType   = descIn[3:2];
    rangeBad   = (descType != 2'd3) &&
                 ((vaIn >> (LARGE_SH + IDX_W * (int'(descType) + 1))) != '0);
    startLevel = {1'b0, descType} + 3'd1;
    startAddr  = {descIn[VA_W-1:PAGE_SH], {PAGE_SH{1'b0}}} + tableOffset(startLevel, vaIn);
    needWalk   = xlateEn && !badSpace && !rangeBad && !descIn[5];
  end

  // ---- walk state ----
  logic [VA_W-1:0]  vaQ;
  logic [1:0]       scQ, accQ;
  logic             secMaskQ, largeQ;
  logic [LVL_W-1:0] levelQ;

  // ---- entry evaluation ----
  logic [VA_W-1:0]   ent, leafRa, nextAddr;
  logic [LVL_W-1:0]  nextLevel;
  logic [1:0]        expType;
  logic              entFault, leaf, leafRo;
  logic [CODE_W-1:0] entCode;
  logic              unusedBits;

  assign ent        = memRspData;
  assign unusedBits = ^{ent[8:6], ent[4], ent[1:0]};

  always_comb begin
    entFault  = 1'b0;
    entCode   = '0;
    leaf      = 1'b0;
    leafRo    = 1'b0;
    leafRa    = '0;
    nextLevel = levelQ - 3'd1;
    nextAddr  = {ent[VA_W-1:PAGE_SH], {PAGE_SH{1'b0}}} + tableOffset(levelQ - 3'd1, vaQ);
    expType   = (levelQ >= 3'd2) ? 2'(levelQ - 3'd2) : 2'd0;
    if (levelQ == '0) begin
      if (ent[10]) begin
        entFault = 1'b1; entCode = FC_PAGEX;
      end else begin
        leaf = 1'b1; leafRo = ent[9];
        leafRa = {ent[VA_W-1:PAGE_SH], {PAGE_SH{1'b0}}};
      end
    end else if (ent[5]) begin
      entFault = 1'b1; entCode = FC_SEGX;
    end else if (ent[3:2] != expType) begin
      entFault = 1'b1; entCode = FC_SPEC;
    end else if (levelQ == 3'd1) begin
      if (largeQ && ent[10]) begin
        leaf = 1'b1; leafRo = ent[9];
        leafRa = {ent[VA_W-1:LARGE_SH], vaQ[LARGE_SH-1:PAGE_SH], {PAGE_SH{1'b0}}};
      end else begin
        nextAddr = {ent[VA_W-1:PAGE_SH-1], {(PAGE_SH-1){1'b0}}} + tableOffset('0, vaQ);
      end
    end
    walkDone = entFault || leaf;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaQ <= '0; scQ <= '0; accQ <= '0; secMaskQ <= 1'b0; largeQ <= 1'b0;
      levelQ <= '0; memReqValid <= 1'b0; memAddr <= '0;
      rspValid <= 1'b0; rspOut <= '0;
    end else begin
      memReqValid <= 1'b0;
      rspValid    <= 1'b0;
      if (strobe.capture) begin
        vaQ <= vaIn; scQ <= scIn; accQ <= reqAccess;
        secMaskQ <= secMaskIn; largeQ <= largePageEn;
        if (needWalk) begin
          memReqValid <= 1'b1;
          memAddr     <= startAddr;
          levelQ      <= startLevel;
        end else begin
          rspValid <= 1'b1;
          if (!xlateEn)      rspOut <= leafRsp(vaIn, 1'b0, reqAccess, 1'b0, vaIn, scIn);
          else if (badSpace) rspOut <= faultRsp(FC_SPEC, vaIn);
          else if (rangeBad) rspOut <= faultRsp(FC_SPEC, vaIn | VA_W'(scIn));
          else               rspOut <= leafRsp(vaIn, 1'b0, reqAccess, secMaskIn, vaIn, scIn);
        end
      end else if (strobe.step) begin
        if (walkDone) begin
          rspValid <= 1'b1;
          rspOut   <= entFault ? faultRsp(entCode, vaQ | VA_W'(scQ))
                               : leafRsp(leafRa, leafRo, accQ, secMaskQ, vaQ, scQ);
        end else begin
          memReqValid <= 1'b1;
          memAddr     <= nextAddr;
          levelQ      <= nextLevel;
        end
      end
    end
  end

  assert_single_read_R13: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);
  assert_level_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> levelQ <= TOP_LVL);
  assert_fault_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspOut.fault) |-> (rspOut.raddr == '0 && rspOut.perm == '0));
  assert_prot_word_R11: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspOut.fault && rspOut.code == FC_PROT) |-> (rspOut.word[2] && rspOut.word[1:0] != 2'b00));
  assert_sec_fetch_perm_R12: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspOut.fault && secMaskQ && accQ == ACC_FETCH) |-> rspOut.perm == 3'b100);
endmodule

// File: rtl/page_walker.sv
module page_walker
  import walk_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [VA_W-1:0]    reqVaddr,
  input  logic [1:0]         reqAccess,
  input  logic [1:0]         reqSpace,
  input  logic               xlateEn,
  input  logic               addr64,
  input  logic               largePageEn,
  input  logic [VA_W-1:0]    descPrimary,
  input  logic [VA_W-1:0]    descSecondary,
  input  logic [VA_W-1:0]    descHome,
  output logic               memReqValid,
  output logic [VA_W-1:0]    memAddr,
  input  logic               memRspValid,
  input  logic [VA_W-1:0]    memRspData,
  output logic               rspValid,
  output logic [VA_W-1:0]    rspRaddr,
  output logic [PERM_W-1:0]  rspPerm,
  output logic               rspFault,
  output logic [CODE_W-1:0]  rspCode,
  output logic [VA_W-1:0]    rspExcWord
);
  walkStrobe_t strobe;
  logic needWalk, walkDone;
  rsp_t rspOut;

  walk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .needWalk(needWalk),
    .memRspValid(memRspValid), .walkDone(walkDone), .reqReady(reqReady), .strobe(strobe)
  );

  walk_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqVaddr(reqVaddr), .reqAccess(reqAccess),
    .reqSpace(reqSpace), .xlateEn(xlateEn), .addr64(addr64), .largePageEn(largePageEn),
    .descPrimary(descPrimary), .descSecondary(descSecondary), .descHome(descHome),
    .memRspData(memRspData), .needWalk(needWalk), .walkDone(walkDone),
    .memReqValid(memReqValid), .memAddr(memAddr), .rspValid(rspValid), .rspOut(rspOut)
  );

  assign rspRaddr   = rspOut.raddr;
  assign rspPerm    = rspOut.perm;
  assign rspFault   = rspOut.fault;
  assign rspCode    = rspOut.code;
  assign rspExcWord = rspOut.word;

  assert_ready_low_R13: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !reqReady);
  assert_idle_on_result_R1: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> reqReady);
endmodule

// File: tb/tb_page_walker.sv
module tb_page_walker;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqReady;
  logic [63:0] reqVaddr = '0;
  logic [1:0] reqAccess = '0, reqSpace = '0;
  logic xlateEn = 1'b1, addr64 = 1'b1, largePageEn = 1'b0;
  logic [63:0] descPrimary, descSecondary, descHome;
  logic memReqValid, memRspValid = 1'b0;
  logic [63:0] memAddr, memRspData = '0;
  logic rspValid, rspFault;
  logic [63:0] rspRaddr, rspExcWord;
  logic [2:0] rspPerm;
  logic [7:0] rspCode;

  int checks = 0, errors = 0, reads = 0, overlaps = 0;
  bit done = 1'b0;
  logic [63:0] memImg [logic [63:0]];

  always #(CLK_PERIOD/2) clk = ~clk;

  page_walker dut (.*);

  // table memory responder: answers each read two cycles after the request
  initial begin
    logic [63:0] a;
    @(negedge clk);
    forever begin
      if (memRspValid) memRspValid = 1'b0;
      if (memReqValid) begin
        a = memAddr;
        reads++;
        @(negedge clk);
        if (memReqValid) overlaps++;
        memRspData  = memImg.exists(a) ? memImg[a] : 64'h0;
        memRspValid = 1'b1;
      end
      @(negedge clk);
    end
  end

  typedef struct packed {
    logic [63:0] va; logic [1:0] acc; logic [1:0] sp; logic xl; logic a64; logic lg;
    logic flt; logic [7:0] code; logic [63:0] ra; logic [2:0] perm; logic [63:0] word;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{64'h0000_0000_8012_3ABC, 2'b00, 2'b00, 1, 1, 0, 0, 8'h00, 64'hABCD_E000, 3'b111, 64'h0, 8'd7},  // R7 R9
    '{64'h0000_0000_8012_4000, 2'b00, 2'b00, 1, 1, 0, 0, 8'h00, 64'h1234_5000, 3'b101, 64'h0, 8'd11}, // R11 ro read
    '{64'h0000_0000_8012_4010, 2'b01, 2'b00, 1, 1, 0, 1, 8'h04, 64'h0, 3'b000, 64'h8012_4005, 8'd11}, // R11 prot
    '{64'h0000_0000_8012_5000, 2'b00, 2'b00, 1, 1, 0, 1, 8'h11, 64'h0, 3'b000, 64'h8012_5001, 8'd9},  // R9 invalid
    '{64'h0000_0000_8025_6000, 2'b00, 2'b00, 1, 1, 1, 0, 8'h00, 64'h0775_6000, 3'b111, 64'h0, 8'd10}, // R10 large
    '{64'h0000_0000_8025_6000, 2'b00, 2'b00, 1, 1, 0, 0, 8'h00, 64'h0099_9000, 3'b111, 64'h0, 8'd10}, // R10 disabled
    '{64'h0000_0000_8031_0000, 2'b01, 2'b00, 1, 1, 1, 1, 8'h04, 64'h0, 3'b000, 64'h8031_0005, 8'd11}, // R11 large prot
    '{64'h0000_0000_8031_0000, 2'b00, 2'b00, 1, 1, 1, 0, 8'h00, 64'h0881_0000, 3'b101, 64'h0, 8'd11}, // R11 large ro
    '{64'h0000_0000_8040_0000, 2'b00, 2'b00, 1, 1, 0, 1, 8'h10, 64'h0, 3'b000, 64'h8040_0001, 8'd8},  // R8 seg invalid
    '{64'h0000_0000_8050_0000, 2'b00, 2'b00, 1, 1, 0, 1, 8'h12, 64'h0, 3'b000, 64'h8050_0001, 8'd8},  // R8 seg type
    '{64'h0000_0001_0000_0000, 2'b00, 2'b00, 1, 1, 0, 1, 8'h10, 64'h0, 3'b000, 64'h1_0000_0001, 8'd8}, // R8 region invalid
    '{64'h0000_0001_8000_0000, 2'b00, 2'b00, 1, 1, 0, 1, 8'h12, 64'h0, 3'b000, 64'h1_8000_0001, 8'd8}, // R8 region type
    '{64'h0000_0400_0000_0000, 2'b00, 2'b00, 1, 1, 0, 1, 8'h12, 64'h0, 3'b000, 64'h0400_0000_0001, 8'd5}, // R5
    '{64'h0020_0000_0000_1000, 2'b00, 2'b11, 1, 1, 0, 0, 8'h00, 64'hFE_DCBA_9000, 3'b111, 64'h0, 8'd7}, // R7 five levels
    '{64'h0040_0000_0000_0000, 2'b00, 2'b11, 1, 1, 0, 1, 8'h12, 64'h0, 3'b000, 64'h0040_0000_0000_0003, 8'd8}, // R8 home
    '{64'h0000_0000_0030_5000, 2'b00, 2'b10, 1, 1, 0, 0, 8'h00, 64'h00C0_5000, 3'b011, 64'h0, 8'd12}, // R12 data read
    '{64'h0000_0000_0030_5000, 2'b01, 2'b10, 1, 1, 0, 0, 8'h00, 64'h00C0_5000, 3'b011, 64'h0, 8'd12}, // R12 data write
    '{64'h0000_0000_8012_3000, 2'b10, 2'b10, 1, 1, 0, 0, 8'h00, 64'hABCD_E000, 3'b100, 64'h0, 8'd12}, // R12 fetch
    '{64'h0000_0000_0060_0000, 2'b00, 2'b10, 1, 1, 0, 1, 8'h10, 64'h0, 3'b000, 64'h0060_0002, 8'd12}, // R12 word
    '{64'h0000_0000_8000_0000, 2'b00, 2'b10, 1, 1, 0, 1, 8'h12, 64'h0, 3'b000, 64'h8000_0002, 8'd5},  // R5 segment range
    '{64'hFFFF_FFFF_8012_3ABC, 2'b00, 2'b00, 1, 0, 0, 0, 8'h00, 64'hABCD_E000, 3'b111, 64'h0, 8'd3},  // R3
    '{64'h1234_5678_9ABC_DEF0, 2'b01, 2'b00, 0, 1, 0, 0, 8'h00, 64'h1234_5678_9ABC_D000, 3'b111, 64'h0, 8'd2}, // R2
    '{64'h1234_5678_9ABC_DEF0, 2'b01, 2'b10, 0, 0, 0, 0, 8'h00, 64'h1ABC_D000, 3'b111, 64'h0, 8'd3}, // R3 untranslated
    '{64'h0000_0000_8012_3000, 2'b00, 2'b01, 1, 1, 0, 1, 8'h12, 64'h0, 3'b000, 64'h8012_3000, 8'd4},  // R4
    '{64'h0000_0000_8012_3000, 2'b10, 2'b00, 1, 1, 0, 0, 8'h00, 64'hABCD_E000, 3'b111, 64'h0, 8'd12}  // R12 primary fetch
  };

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // drive one request from a negedge and wait for its result pulse
  task automatic translate(input logic [63:0] va, input logic [1:0] acc, input logic [1:0] sp,
                           input logic xl, input logic a64, input logic lg);
    int n;
    reqVaddr = va; reqAccess = acc; reqSpace = sp; xlateEn = xl; addr64 = a64; largePageEn = lg;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    n = 0;
    while (!rspValid && n < 100) begin @(negedge clk); n++; end
  endtask

  initial begin
    // primary: third-region type, origin 0x10000
    descPrimary   = 64'h0001_0004;
    descSecondary = 64'h0002_0000;
    descHome      = 64'h0003_000C;
    memImg[64'h10000] = 64'h40000;        memImg[64'h10008] = 64'h40000;
    memImg[64'h10010] = 64'h20;           memImg[64'h10018] = 64'h40004;
    memImg[64'h40008] = 64'h50000;        memImg[64'h40010] = 64'h0770_0400;
    memImg[64'h40018] = 64'h0880_0600;    memImg[64'h40020] = 64'h20;
    memImg[64'h40028] = 64'h50004;
    memImg[64'h50118] = 64'hABCD_E000;    memImg[64'h50120] = 64'h1234_5200;
    memImg[64'h50128] = 64'h400;          memImg[64'h077002B0] = 64'h0099_9000;
    memImg[64'h30008] = 64'h31008;        memImg[64'h30010] = 64'h31004;
    memImg[64'h31000] = 64'h32004;        memImg[64'h32000] = 64'h33000;
    memImg[64'h33000] = 64'h34000;        memImg[64'h34008] = 64'hFE_DCBA_9000;
    memImg[64'h20018] = 64'h60000;        memImg[64'h20030] = 64'h20;
    memImg[64'h60028] = 64'h00C0_5000;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(reqReady == 1'b1, "R1 reqReady after reset", 64'(reqReady), 64'h1);
    check(rspValid == 1'b0 && memReqValid == 1'b0, "R1 outputs idle after reset",
          64'({rspValid, memReqValid}), 64'h0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      translate(v.va, v.acc, v.sp, v.xl, v.a64, v.lg);
      check(rspValid && rspFault == v.flt && rspCode == v.code,
            $sformatf("R%0d vec %0d fault/code", v.req, i), {55'h0, rspFault, rspCode}, {55'h0, v.flt, v.code});
      check(rspRaddr == v.ra && rspPerm == v.perm,
            $sformatf("R%0d vec %0d raddr/perm", v.req, i), rspRaddr ^ 64'(rspPerm), v.ra ^ 64'(v.perm));
      check(rspExcWord == v.word, $sformatf("R%0d vec %0d word", v.req, i), rspExcWord, v.word);
      @(negedge clk);
      check(rspValid == 1'b0, "R1 result is a single pulse", 64'(rspValid), 64'h0);
    end

    // R2: translation off makes no memory read
    reads = 0;
    translate(64'h0000_0000_5555_5000, 2'b00, 2'b00, 1'b0, 1'b1, 1'b0);
    check(reads == 0 && rspRaddr == 64'h5555_5000, "R2 no read when off", 64'(reads), 64'h0);
    @(negedge clk);

    // R6: real-space descriptor bypass
    descHome = 64'h0003_002C;
    reads = 0;
    translate(64'h0000_7777_1234_5678, 2'b01, 2'b11, 1'b1, 1'b1, 1'b0);
    check(!rspFault && rspRaddr == 64'h0000_7777_1234_5000, "R6 real-space raddr", rspRaddr, 64'h0000_7777_1234_5000);
    check(rspPerm == 3'b111 && reads == 0, "R6 full perm, no read", 64'({reads[3:0], rspPerm}), 64'h7);
    descHome = 64'h0003_000C;
    @(negedge clk);

    // R13: ready low throughout a five-level walk, one read at a time
    reads = 0; overlaps = 0;
    reqVaddr = 64'h0020_0000_0000_1000; reqAccess = 2'b00; reqSpace = 2'b11;
    xlateEn = 1'b1; addr64 = 1'b1; largePageEn = 1'b0;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    begin
      int busyLow = 0, n = 0;
      while (!rspValid && n < 100) begin
        if (reqReady) busyLow++;
        @(negedge clk); n++;
      end
      check(busyLow == 0, "R13 ready low during walk", 64'(busyLow), 64'h0);
      check(reqReady == 1'b1, "R13 ready with result", 64'(reqReady), 64'h1);
    end
    check(reads == 5 && overlaps == 0, "R13 five serial reads", 64'({overlaps[7:0], reads[7:0]}), 64'h5);
    check(rspRaddr == 64'hFE_DCBA_9000, "R7 five-level result", rspRaddr, 64'hFE_DCBA_9000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R13 actual=%h expected=%h", 64'h0, 64'h1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule